// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Framer

This block sits on the receive side of a 4-bit media-independent interface. It watches the data-valid strobe and the data nibble on every receive clock. It looks for a run of preamble nibbles followed by the start-of-frame nibble. Once it has found that pattern, it joins the payload nibbles in pairs into bytes, taking the low half first. It then passes the bytes downstream on a valid/data/last stream.

The end of a frame is only known when data-valid falls. For that reason the framer holds each completed byte back until the next byte completes or the frame ends. The final byte can then carry the last marker together with an error flag. The error flag covers two cases: a frame that ends on an unpaired nibble, and a receive-error indication seen at any point while data-valid was high.

A frame that breaks the expected pattern before the start-of-frame nibble is dropped. The framer then ignores the line until data-valid goes low. CRC checking, address filtering and clock-domain crossing belong to other blocks.

Top module: `mii_rx_framer`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `byte_valid`, `byte_last`, `byte_err` and `sof_pulse` are all 0.
- R2: `sof_pulse` is high for exactly one cycle, on the cycle after the clock edge that samples nibble 0xD with `rx_dv` high. That 0xD must follow at least one preamble nibble 0x5 of the same frame.
- R3: Payload nibbles pair into bytes with the first nibble after 0xD as bits 3:0 and the next nibble as bits 7:4, and so on for every pair.
- R4: The last complete byte of a frame appears with `byte_valid` and `byte_last` both high, on the cycle after the edge that first samples `rx_dv` low.
- R5: Every byte other than the last appears in frame order with `byte_last` and `byte_err` at 0. It is presented on the cycle after the edge that completes the following byte.
- R6: If `rx_dv` falls after an odd number of payload nibbles, the unpaired nibble is discarded and `byte_err` is 1 alongside the final complete byte.
- R7: If `rx_er` is sampled high while `rx_dv` is high, anywhere from the first preamble nibble to the end of the frame, `byte_err` is 1 alongside that frame's final byte.
- R8: Any nibble other than 0x5 or 0xD sampled during the preamble aborts the frame. After an abort there is no `sof_pulse` and no byte until `rx_dv` has been sampled low, even if 0xD and payload follow.
- R9: A frame whose first nibble with `rx_dv` high is 0xD, with no 0x5 before it, is aborted as in R8.
- R10: If `rx_dv` falls during the preamble, nothing is output, and a frame that starts afterwards is received normally.
- R11: A frame with fewer than two payload nibbles produces its `sof_pulse` but no byte.
- R12: `byte_err` is never high without `byte_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_dv | input | 1 | Data-valid strobe from the line interface |
| rx_nib | input | 4 | Received data nibble |
| rx_er | input | 1 | Receive-error indication |
| byte_valid | output | 1 | A byte is present on `byte_data` this cycle |
| byte_data | output | 8 | Assembled byte |
| byte_last | output | 1 | Marks the final byte of a frame |
| byte_err | output | 1 | Error status of the frame, valid with `byte_last` |
| sof_pulse | output | 1 | One-cycle pulse when start-of-frame is accepted |

## Verification
Every output is registered once. `sof_pulse` is due on the cycle after the 0xD nibble is sampled, and the final byte on the cycle after `rx_dv` is first sampled low. Each earlier byte is due on the cycle after the edge that completes the byte following it. The bench changes inputs on the falling clock edge, and the monitor samples outputs on the falling edge that follows the edge producing them. The monitor pops one expected item per `sof_pulse` or `byte_valid`, so any extra, missing or reordered output is reported. Checker properties tie `sof_pulse` and `byte_last` to the input values sampled exactly one edge earlier.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_PREAM = 2'd1,
        RX_BODY  = 2'd2,
        RX_FLUSH = 2'd3
    } rx_phase_e;

endpackage

// File: rtl/mii_rx_nib_class.sv
module mii_rx_nib_class #(
    parameter int          NIB_W    = 4,
    parameter logic [3:0]  PRE_CODE = 4'h5,
    parameter logic [3:0]  SFD_CODE = 4'hD
) (
    input  logic [NIB_W-1:0] nib,
    output logic             is_pre,
    output logic             is_sfd
);

    localparam logic [NIB_W-1:0] PRE_V = NIB_W'(PRE_CODE);
    localparam logic [NIB_W-1:0] SFD_V = NIB_W'(SFD_CODE);

    always_comb begin
        is_pre = (nib == PRE_V);
        is_sfd = (nib == SFD_V);
    end

endmodule

// File: rtl/mii_rx_core.sv
module mii_rx_core
    import mii_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dv,
    input  logic [NIB_W-1:0]   nib,
    input  logic               er,
    input  logic               is_pre,
    input  logic               is_sfd,
    output logic               o_valid,
    output logic [2*NIB_W-1:0] o_data,
    output logic               o_last,
    output logic               o_err,
    output logic               o_sof
);

    localparam int BYTE_W = 2 * NIB_W;

    typedef struct packed {
        rx_phase_e          phase;
        logic [NIB_W-1:0]   low_nib;
        logic               half;
        logic [BYTE_W-1:0]  held;
        logic               have;
        logic               bad;
        logic               valid;
        logic [BYTE_W-1:0]  data;
        logic               last;
        logic               err;
        logic               sof;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.last  = 1'b0;
        st_d.err   = 1'b0;
        st_d.sof   = 1'b0;
        unique case (st_q.phase)
            RX_IDLE: begin
                if (dv) begin
                    st_d.bad   = er;
                    st_d.phase = is_pre ? RX_PREAM : RX_FLUSH;
                end
            end
            RX_PREAM: begin
                if (!dv) begin
                    st_d.phase = RX_IDLE;
                end else begin
                    if (er) st_d.bad = 1'b1;
                    if (is_sfd) begin
                        st_d.phase = RX_BODY;
                        st_d.sof   = 1'b1;
                        st_d.half  = 1'b0;
                        st_d.have  = 1'b0;
                    end else if (!is_pre) begin
                        st_d.phase = RX_FLUSH;
                    end
                end
            end
            RX_BODY: begin
                if (dv) begin
                    if (er) st_d.bad = 1'b1;
                    if (!st_q.half) begin
                        st_d.low_nib = nib;
                        st_d.half    = 1'b1;
                    end else begin
                        st_d.half = 1'b0;
                        st_d.held = {nib, st_q.low_nib};
                        st_d.have = 1'b1;
                        if (st_q.have) begin
                            st_d.valid = 1'b1;
                            st_d.data  = st_q.held;
                        end
                    end
                end else begin
                    st_d.phase = RX_IDLE;
                    st_d.have  = 1'b0;
                    st_d.half  = 1'b0;
                    if (st_q.have) begin
                        st_d.valid = 1'b1;
                        st_d.data  = st_q.held;
                        st_d.last  = 1'b1;
                        st_d.err   = st_q.bad | st_q.half;
                    end
                end
            end
            default: begin
                if (!dv) st_d.phase = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: RX_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid = st_q.valid;
    assign o_data  = st_q.data;
    assign o_last  = st_q.last;
    assign o_err   = st_q.err;
    assign o_sof   = st_q.sof;

endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer #(
    parameter int         NIB_W    = 4,
    parameter logic [3:0] PRE_CODE = 4'h5,
    parameter logic [3:0] SFD_CODE = 4'hD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_dv,
    input  logic [NIB_W-1:0]   rx_nib,
    input  logic               rx_er,
    output logic               byte_valid,
    output logic [2*NIB_W-1:0] byte_data,
    output logic               byte_last,
    output logic               byte_err,
    output logic               sof_pulse
);

    logic nib_pre, nib_sfd;

    mii_rx_nib_class #(
        .NIB_W    (NIB_W),
        .PRE_CODE (PRE_CODE),
        .SFD_CODE (SFD_CODE)
    ) u_class (
        .nib    (rx_nib),
        .is_pre (nib_pre),
        .is_sfd (nib_sfd)
    );

    mii_rx_core #(
        .NIB_W (NIB_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .dv      (rx_dv),
        .nib     (rx_nib),
        .er      (rx_er),
        .is_pre  (nib_pre),
        .is_sfd  (nib_sfd),
        .o_valid (byte_valid),
        .o_data  (byte_data),
        .o_last  (byte_last),
        .o_err   (byte_err),
        .o_sof   (sof_pulse)
    );

endmodule

// File: rtl/mii_rx_framer_checker.sv
module mii_rx_framer_checker #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_dv,
    input logic [NIB_W-1:0] rx_nib,
    input logic             byte_valid,
    input logic             byte_last,
    input logic             byte_err,
    input logic             sof_pulse
);

    assert_sof_after_sfd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |-> ($past(rx_dv) && $past(rx_nib) == NIB_W'(4'hD)));

    assert_sof_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sof_pulse |=> !sof_pulse);

    assert_last_after_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> (byte_valid && !$past(rx_dv)));

    assert_err_only_last_R12: assert property (@(posedge clk) disable iff (!rst_n)
        byte_err |-> byte_last);

    assert_no_sof_with_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !sof_pulse);

endmodule

bind mii_rx_framer mii_rx_framer_checker #(.NIB_W(NIB_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .rx_nib     (rx_nib),
    .byte_valid (byte_valid),
    .byte_last  (byte_last),
    .byte_err   (byte_err),
    .sof_pulse  (sof_pulse)
);

// File: tb/mii_rx_framer_bench.sv
module mii_rx_framer_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b0;
    logic [3:0] rx_nib = 4'h0;
    logic       rx_er = 1'b0;
    logic       byte_valid, byte_last, byte_err, sof_pulse;
    logic [7:0] byte_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_sof;
        logic [7:0] data;
        bit         last;
        bit         err;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    mii_rx_framer u_mii_rx_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_dv      (rx_dv),
        .rx_nib     (rx_nib),
        .rx_er      (rx_er),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_err   (byte_err),
        .sof_pulse  (sof_pulse)
    );

    task automatic check(bit ok, string req, string what);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    task automatic put(bit dv, logic [3:0] nib, bit er);
        rx_dv  = dv;
        rx_nib = nib;
        rx_er  = er;
        @(negedge clk);
    endtask

    task automatic push_sof(string req);
        exp_t e;
        e.is_sof = 1'b1; e.data = '0; e.last = 1'b0; e.err = 1'b0; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic push_byte(logic [7:0] d, bit last, bit err, string req);
        exp_t e;
        e.is_sof = 1'b0; e.data = d; e.last = last; e.err = err; e.req = req;
        exp_q.push_back(e);
    endtask

    // Well-formed frame: npre preamble nibbles, SFD, nbytes bytes low nibble first,
    // an optional trailing odd nibble, rx_er on payload nibble er_at (-1 = none).
    task automatic send_frame(int npre, int nbytes, bit odd, int er_at,
                              logic [7:0] seed, string req, int gap);
        logic [7:0] b;
        int k = 0;
        push_sof(req);
        for (int i = 0; i < nbytes; i++) begin
            b = seed + 8'(i * 37);
            push_byte(b, i == nbytes - 1, (i == nbytes - 1) && (odd || er_at >= 0), req);
        end
        for (int i = 0; i < npre; i++) put(1'b1, 4'h5, 1'b0);
        put(1'b1, 4'hD, 1'b0);
        for (int i = 0; i < nbytes; i++) begin
            b = seed + 8'(i * 37);
            put(1'b1, b[3:0], k == er_at); k++;
            put(1'b1, b[7:4], k == er_at); k++;
        end
        if (odd) put(1'b1, 4'hA, k == er_at);
        for (int i = 0; i < gap; i++) put(1'b0, 4'h0, 1'b0);
    endtask

    always @(negedge clk) begin
        if (rst_n && sof_pulse) begin
            if (exp_q.size() == 0 || !exp_q[0].is_sof) begin
                check(1'b0, (exp_q.size() == 0) ? "R8" : exp_q[0].req,
                      "unexpected sof_pulse: actual 1 expected 0");
            end else begin
                check(1'b1, exp_q[0].req, "");
                void'(exp_q.pop_front());
            end
        end
        if (rst_n && byte_valid) begin
            if (exp_q.size() == 0 || exp_q[0].is_sof) begin
                check(1'b0, (exp_q.size() == 0) ? "R8" : exp_q[0].req,
                      $sformatf("unexpected byte: actual %h expected none", byte_data));
            end else begin
                check(byte_data == exp_q[0].data && byte_last == exp_q[0].last &&
                      byte_err == exp_q[0].err, exp_q[0].req,
                      $sformatf("byte actual d=%h l=%0d e=%0d expected d=%h l=%0d e=%0d",
                                byte_data, byte_last, byte_err,
                                exp_q[0].data, exp_q[0].last, exp_q[0].err));
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (finished) return;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run hung: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        check(!byte_valid && !byte_last && !byte_err && !sof_pulse, "R1",
              $sformatf("reset outputs actual %0d%0d%0d%0d expected 0000",
                        byte_valid, byte_last, byte_err, sof_pulse));
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_valid && !sof_pulse, "R1", "outputs after release actual nonzero expected 0");

        // R2 R3 R4 R5: nominal frame, long preamble
        send_frame(15, 4, 1'b0, -1, 8'h10, "R3", 3);
        // R4: single-byte frame
        send_frame(7, 1, 1'b0, -1, 8'hC3, "R4", 2);
        // R6: odd trailing nibble
        send_frame(3, 3, 1'b1, -1, 8'h5A, "R6", 2);
        // R7 R12: rx_er in the payload, middle bytes clean
        send_frame(15, 5, 1'b0, 4, 8'h21, "R7", 2);

        // R8: bad nibble in preamble, then SFD and payload ignored
        put(1'b1, 4'h5, 1'b0); put(1'b1, 4'h5, 1'b0); put(1'b1, 4'hA, 1'b0);
        put(1'b1, 4'h5, 1'b0); put(1'b1, 4'hD, 1'b0);
        for (int i = 0; i < 6; i++) put(1'b1, 4'(i), 1'b0);
        put(1'b0, 4'h0, 1'b0); put(1'b0, 4'h0, 1'b0);
        send_frame(5, 2, 1'b0, -1, 8'h99, "R8", 2);

        // R9: SFD with no preamble
        put(1'b1, 4'hD, 1'b0);
        for (int i = 0; i < 6; i++) put(1'b1, 4'(i + 3), 1'b0);
        put(1'b0, 4'h0, 1'b0); put(1'b0, 4'h0, 1'b0);
        send_frame(2, 2, 1'b0, -1, 8'h47, "R9", 2);

        // R10: dv drops inside the preamble
        put(1'b1, 4'h5, 1'b0); put(1'b1, 4'h5, 1'b0); put(1'b1, 4'h5, 1'b0);
        put(1'b0, 4'h0, 1'b0);
        send_frame(4, 3, 1'b0, -1, 8'hE0, "R10", 1);

        // R11: zero payload and one-nibble payload
        send_frame(6, 0, 1'b0, -1, 8'h00, "R11", 2);
        send_frame(6, 0, 1'b1, -1, 8'h00, "R11", 2);

        // R7: rx_er during the preamble
        push_sof("R7");
        push_byte(8'h3C, 1'b0, 1'b0, "R7");
        push_byte(8'h81, 1'b1, 1'b1, "R7");
        put(1'b1, 4'h5, 1'b0); put(1'b1, 4'h5, 1'b1); put(1'b1, 4'hD, 1'b0);
        put(1'b1, 4'hC, 1'b0); put(1'b1, 4'h3, 1'b0);
        put(1'b1, 4'h1, 1'b0); put(1'b1, 4'h8, 1'b0);
        put(1'b0, 4'h0, 1'b0);

        // R5: back-to-back frames with a one-cycle gap
        send_frame(1, 3, 1'b0, -1, 8'h6B, "R5", 1);
        send_frame(1, 2, 1'b0, -1, 8'hF4, "R5", 4);

        check(exp_q.size() == 0, "R5",
              $sformatf("pending expected items actual %0d expected 0", exp_q.size()));
        finish_run();
    end

endmodule